// File: doc/BRIEF.md
# Serial flash erase sequencer

This block erases a page-aligned byte range of a serial flash device that uses
page/block erase commands. A host pulses `start_i` with a linear byte offset and
a byte length. The page size and the page-address shift of the attached device
come from static configuration pins and are captured when the request starts.
The block first divides the offset and the length by the page size. Either
remainder being non-zero ends the request at once with an alignment error, and
no bus traffic is issued.

For each erase unit the sequencer chooses one of two erases. A block erase covers
8 pages and is used when the current page is 8-page aligned and at least 8 pages
remain. Otherwise it issues a single-page erase. It sends a 4-byte command, then
polls the device status with 2-byte status reads until the ready bit is set or a
timeout expires. After a successful unit, the page number advances and the
remaining count drops by the size erased. A one-cycle `done_o` pulse ends every
request, and `err_code_o` holds the outcome until the next start.

Bytes reach the SPI byte master on a valid/ready stream. The sequencer presents
one byte with `tx_valid_o` and holds it, unchanged, until `tx_ready_i` accepts
it. It then raises `rx_ready_o` and waits for the byte exchanged in return on
`rx_valid_i`. Only one byte is ever outstanding, so back-pressure on either side
simply stretches the sequence.

Top module: `df_erase_seq`

## Requirements
- R1: An offset or length that is not a whole multiple of the captured page size, or a page size of zero, ends the request with `err_code_o` = 2'b01 and no byte is sent (`cs_n_o` stays high, `tx_valid_o` stays low).
- R2: An aligned request of length zero ends with `done_o` and `err_code_o` = 2'b00 and no bus traffic; `done_o` is a single-cycle pulse.
- R3: Opcode 0x50 (block erase) is sent when the current page number has its three low bits zero and at least 8 pages remain; otherwise opcode 0x81 (page erase) is sent.
- R4: An erase command is exactly 4 bytes: the opcode, device address bits 23:16, bits 15:8, bits 7:0, where the 24-bit device address is the page number shifted left by `page_shift_i`.
- R5: After each erase command the block issues status reads of exactly two bytes, 0xD7 then 0x00; the byte returned for the second is the status, and its bit 7 set means ready.
- R6: After a ready status the page number and the remaining page count advance by 8 for a block erase and by 1 for a page erase; the request ends with `err_code_o` = 2'b00 when none remain.
- R7: If a not-ready status arrives once `TIMEOUT_CYCLES` cycles have passed since the end of the erase command, the request ends with `err_code_o` = 2'b10 and no further command is sent.
- R8: `cs_n_o` is low for the whole of each command and each status read, high for at least one cycle between them, and high while idle; `tx_valid_o` is only asserted while `cs_n_o` is low.
- R9: While `tx_valid_o` is high and `tx_ready_i` low, `tx_data_o` and `tx_valid_o` hold; a new byte is offered only after the reply byte of the previous one is taken with `rx_ready_o` high.
- R10: Page size and page shift are captured at start; changing the pins during a request has no effect on its commands.
- R11: `start_i` is ignored while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse, taken when idle |
| offset_i | input | OFS_W | Start byte offset |
| length_i | input | OFS_W | Length in bytes |
| page_size_i | input | PSZ_W | Device page size in bytes |
| page_shift_i | input | SHF_W | Left shift from page number to device address |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle end-of-request pulse |
| err_code_o | output | 2 | 00 ok, 01 misaligned, 10 timeout |
| cs_n_o | output | 1 | Device select, active low |
| tx_valid_o | output | 1 | Byte to send is valid |
| tx_ready_i | input | 1 | Byte master accepts the byte |
| tx_data_o | output | 8 | Byte to send |
| rx_valid_i | input | 1 | Returned byte is valid |
| rx_ready_o | output | 1 | Sequencer waits for a returned byte |
| rx_data_i | input | 8 | Returned byte |

## Verification
The hardest case to reach is a poll timeout that comes after a run of not-ready
status bytes. The bench's device model answers every status read with the ready
bit clear for a programmable number of polls. The bench shortens `TIMEOUT_CYCLES`
and asks for far more busy polls than fit in the window, so the request stops
after its first command. The mixed block/page split needs a range that starts on
an 8-page boundary with a tail shorter than 8 pages. The bench also uses several
page-size and shift pairs, and stalls `tx_ready_i` on an irregular pattern
throughout.

// File: rtl/df_erase_pkg.sv
package df_erase_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DIV, ST_CMD, ST_GAP, ST_POLL, ST_FIN
  } st_t;

  localparam logic [7:0] OP_BLOCK_ERASE = 8'h50;
  localparam logic [7:0] OP_PAGE_ERASE  = 8'h81;
  localparam logic [7:0] OP_STATUS      = 8'hD7;
  localparam logic [7:0] STAT_RDY_MASK  = 8'h80;

  localparam logic [1:0] ERR_NONE  = 2'b00;
  localparam logic [1:0] ERR_ALIGN = 2'b01;
  localparam logic [1:0] ERR_TMO   = 2'b10;
endpackage

// File: rtl/df_udiv.sv
module df_udiv #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  acc_q, q_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;
  logic [W:0]    sh;
  logic          ge;

  always_comb begin
    sh = {acc_q, q_q[W-1]};
    ge = sh >= {1'b0, divisor};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      q_q    <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (start) begin
      acc_q  <= '0;
      q_q    <= dividend;
      cnt_q  <= CW'(W);
      done_q <= 1'b0;
    end else if (cnt_q != '0) begin
      acc_q  <= ge ? W'(sh - {1'b0, divisor}) : sh[W-1:0];
      q_q    <= {q_q[W-2:0], ge};
      cnt_q  <= cnt_q - 1'b1;
      done_q <= (cnt_q == CW'(1));
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done = done_q;
  assign quot = q_q;
  assign rem  = acc_q;

  // R1
  div_rem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && divisor != '0) |-> (rem < divisor));
endmodule

// File: rtl/df_poll_timer.sv
module df_poll_timer #(
  parameter int unsigned LIMIT = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (clr)               cnt_q <= '0;
    else if (cnt_q != CW'(LIMIT)) cnt_q <= cnt_q + 1'b1;
  end

  assign expired = (cnt_q == CW'(LIMIT));

  // R7
  tmr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !clr) |=> expired);
endmodule

// File: rtl/df_erase_seq.sv
module df_erase_seq
  import df_erase_pkg::*;
#(
  parameter int          OFS_W          = 32,
  parameter int          PSZ_W          = 12,
  parameter int          SHF_W          = 4,
  parameter int          ADDR_W         = 24,
  parameter int          BLK_PAGES      = 8,
  parameter int unsigned TIMEOUT_CYCLES = 100_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [OFS_W-1:0] offset_i,
  input  logic [OFS_W-1:0] length_i,
  input  logic [PSZ_W-1:0] page_size_i,
  input  logic [SHF_W-1:0] page_shift_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [1:0]       err_code_o,
  output logic             cs_n_o,
  output logic             tx_valid_o,
  input  logic             tx_ready_i,
  output logic [7:0]       tx_data_o,
  input  logic             rx_valid_i,
  output logic             rx_ready_o,
  input  logic [7:0]       rx_data_i
);
  localparam int BLK_LOG = $clog2(BLK_PAGES);

  st_t              st_q, nxt_q;
  logic [PSZ_W-1:0] psz_q;
  logic [SHF_W-1:0] shf_q;
  logic [OFS_W-1:0] pg_q, rem_q;
  logic [1:0]       idx_q;
  logic             wait_q, done_q;
  logic [1:0]       err_q;

  logic             div_go, off_done, len_done;
  logic [OFS_W-1:0] off_quot, off_rem, len_quot, len_rem, divisor;
  logic             tmr_exp;

  logic              is_blk, last_byte, dev_rdy, misaligned;
  logic [OFS_W-1:0]  step;
  logic [ADDR_W-1:0] dev_addr;

  assign div_go  = (st_q == ST_IDLE) && start_i;
  assign divisor = OFS_W'(psz_q);

  df_udiv #(.W(OFS_W)) u_div_off (
    .clk(clk), .rst_n(rst_n), .start(div_go), .dividend(offset_i),
    .divisor(divisor), .done(off_done), .quot(off_quot), .rem(off_rem)
  );

  df_udiv #(.W(OFS_W)) u_div_len (
    .clk(clk), .rst_n(rst_n), .start(div_go), .dividend(length_i),
    .divisor(divisor), .done(len_done), .quot(len_quot), .rem(len_rem)
  );

  df_poll_timer #(.LIMIT(TIMEOUT_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(st_q == ST_CMD), .expired(tmr_exp)
  );

  always_comb begin
    is_blk     = (pg_q[BLK_LOG-1:0] == '0) && (rem_q >= OFS_W'(BLK_PAGES));
    step       = is_blk ? OFS_W'(BLK_PAGES) : OFS_W'(1);
    dev_addr   = ADDR_W'(pg_q << shf_q);
    last_byte  = (st_q == ST_CMD) ? (idx_q == 2'd3) : (idx_q == 2'd1);
    dev_rdy    = (rx_data_i & STAT_RDY_MASK) != 8'h00;
    misaligned = (off_rem != '0) || (len_rem != '0) || (psz_q == '0);
  end

  always_comb begin
    tx_data_o = 8'h00;
    if (st_q == ST_CMD) begin
      case (idx_q)
        2'd0:    tx_data_o = is_blk ? OP_BLOCK_ERASE : OP_PAGE_ERASE;
        2'd1:    tx_data_o = dev_addr[ADDR_W-1 -: 8];
        2'd2:    tx_data_o = dev_addr[ADDR_W-9 -: 8];
        default: tx_data_o = dev_addr[ADDR_W-17 -: 8];
      endcase
    end else if (st_q == ST_POLL && idx_q == 2'd0) begin
      tx_data_o = OP_STATUS;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      nxt_q  <= ST_IDLE;
      psz_q  <= '0;
      shf_q  <= '0;
      pg_q   <= '0;
      rem_q  <= '0;
      idx_q  <= '0;
      wait_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= ERR_NONE;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (start_i) begin
          psz_q <= page_size_i;
          shf_q <= page_shift_i;
          err_q <= ERR_NONE;
          st_q  <= ST_DIV;
        end
        ST_DIV: if (off_done && len_done) begin
          if (misaligned) begin
            err_q <= ERR_ALIGN;
            st_q  <= ST_FIN;
          end else begin
            pg_q   <= off_quot;
            rem_q  <= len_quot;
            idx_q  <= '0;
            wait_q <= 1'b0;
            st_q   <= (len_quot == '0) ? ST_FIN : ST_CMD;
          end
        end
        ST_CMD, ST_POLL: begin
          if (!wait_q) begin
            if (tx_ready_i) wait_q <= 1'b1;
          end else if (rx_valid_i) begin
            wait_q <= 1'b0;
            if (!last_byte) begin
              idx_q <= idx_q + 1'b1;
            end else begin
              idx_q <= '0;
              if (st_q == ST_CMD) begin
                nxt_q <= ST_POLL;
                st_q  <= ST_GAP;
              end else if (dev_rdy) begin
                pg_q  <= pg_q + step;
                rem_q <= rem_q - step;
                nxt_q <= ST_CMD;
                st_q  <= (rem_q == step) ? ST_FIN : ST_GAP;
              end else if (tmr_exp) begin
                err_q <= ERR_TMO;
                st_q  <= ST_FIN;
              end else begin
                nxt_q <= ST_POLL;
                st_q  <= ST_GAP;
              end
            end
          end
        end
        ST_GAP: st_q <= nxt_q;
        ST_FIN: begin
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (st_q != ST_IDLE);
  assign done_o     = done_q;
  assign err_code_o = err_q;
  assign cs_n_o     = !((st_q == ST_CMD) || (st_q == ST_POLL));
  assign tx_valid_o = ((st_q == ST_CMD) || (st_q == ST_POLL)) && !wait_q;
  assign rx_ready_o = wait_q;

  // R9
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));

  // R8
  tx_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o |-> !cs_n_o);

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R3
  opcode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CMD && idx_q == 2'd0 && tx_valid_o) |->
      (tx_data_o == OP_BLOCK_ERASE || tx_data_o == OP_PAGE_ERASE));

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && st_q != ST_FIN) |=> ($stable(psz_q) && $stable(shf_q)));
endmodule

// File: tb/df_erase_seq_tb.sv
module df_erase_seq_tb;
  localparam int TMO = 300;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] offset_i = '0, length_i = '0;
  logic [11:0] page_size_i = '0;
  logic [3:0]  page_shift_i = '0;
  logic        busy_o, done_o, cs_n_o, tx_valid_o, rx_ready_o;
  logic [1:0]  err_code_o;
  logic [7:0]  tx_data_o;
  logic        tx_ready_i = 1'b0, rx_valid_i = 1'b0;
  logic [7:0]  rx_data_i = '0;

  always #10 clk = ~clk;

  df_erase_seq #(.TIMEOUT_CYCLES(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .offset_i(offset_i),
    .length_i(length_i), .page_size_i(page_size_i), .page_shift_i(page_shift_i),
    .busy_o(busy_o), .done_o(done_o), .err_code_o(err_code_o), .cs_n_o(cs_n_o),
    .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i), .tx_data_o(tx_data_o),
    .rx_valid_i(rx_valid_i), .rx_ready_o(rx_ready_o), .rx_data_i(rx_data_i)
  );

  int total = 0, bad = 0;
  logic [31:0] exp_q[$];
  logic [7:0]  tbuf[8];
  int nb = 0, txn_count = 0, busy_polls = 0, busy_left = 0;
  bit pend = 0, prev_cs = 1;
  int dly = 0, tick = 0;
  logic [7:0] resp = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic end_txn();
    logic [31:0] got, e;
    txn_count++;
    if (nb == 4) begin
      got = {tbuf[0], tbuf[1], tbuf[2], tbuf[3]};
      if (exp_q.size() == 0) chk(0, "R6 unexpected command", got, 0);
      else begin
        e = exp_q.pop_front();
        chk(got == e, "R3 R4 command bytes", got, e);
      end
      busy_left = busy_polls;
    end else if (nb == 2) begin
      chk(tbuf[0] == 8'hD7 && tbuf[1] == 8'h00, "R5 status read", {tbuf[0], tbuf[1]}, 32'hD700);
    end else begin
      chk(0, "R8 transaction length", nb, 4);
    end
    nb = 0;
  endtask

  // device model: byte capture at the clock edge
  always @(posedge clk) begin
    if (rst_n) begin
      if (tx_valid_o && tx_ready_i) begin
        if (nb < 8) tbuf[nb] = tx_data_o;
        nb++;
        pend = 1; dly = 2;
        if (nb == 2 && tbuf[0] == 8'hD7) begin
          if (busy_left > 0) begin resp = 8'h3C; busy_left--; end
          else resp = 8'hBC;
        end else resp = 8'hFF;
      end
      if (!prev_cs && cs_n_o) end_txn();
      prev_cs = cs_n_o;
    end
  end

  // device model: replies and back-pressure away from the edge
  always @(negedge clk) begin
    tick++;
    tx_ready_i = (tick % 5) != 3;
    if (rx_valid_i) rx_valid_i = 1'b0;
    else if (pend) begin
      if (dly > 0) dly--;
      else begin rx_valid_i = 1'b1; rx_data_i = resp; pend = 0; end
    end
  end

  task automatic run(input logic [31:0] off, input logic [31:0] len, input int psz,
                     input int shf, input int bp, input bit tmo, input bit disturb,
                     input string tag);
    logic [1:0] exp_err;
    logic [31:0] a;
    int pg, rm, t0, cyc;
    bit bk, seen;
    exp_q.delete();
    if (psz == 0 || off % psz != 0 || len % psz != 0) exp_err = 2'b01;
    else begin
      exp_err = tmo ? 2'b10 : 2'b00;
      pg = off / psz; rm = len / psz;
      while (rm > 0) begin
        bk = (pg % 8 == 0) && (rm >= 8);
        a = (pg << shf) & 32'hFFFFFF;
        exp_q.push_back({bk ? 8'h50 : 8'h81, a[23:16], a[15:8], a[7:0]});
        if (tmo) break;
        pg += bk ? 8 : 1; rm -= bk ? 8 : 1;
      end
    end
    busy_polls = bp;
    t0 = txn_count;
    @(negedge clk);
    offset_i = off; length_i = len; page_size_i = psz[11:0]; page_shift_i = shf[3:0];
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    seen = 0;
    for (cyc = 0; cyc < 40000 && !seen; cyc++) begin
      @(negedge clk);
      if (disturb && cyc == 40) begin
        page_size_i = 12'd1; page_shift_i = 4'd0; start_i = 1'b1;
      end else start_i = 1'b0;
      if (done_o) seen = 1;
    end
    chk(seen, {tag, " done seen"}, seen, 1);
    chk(err_code_o == exp_err, {tag, " error code"}, err_code_o, exp_err);
    chk(exp_q.size() == 0, "R6 missing commands", exp_q.size(), 0);
    if (exp_err == 2'b01 || len == 0)
      chk(txn_count == t0, "R1 R2 no traffic", txn_count - t0, 0);
    @(negedge clk);
    chk(!done_o && !busy_o, "R2 done single pulse", {done_o, busy_o}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n_o && !tx_valid_o && !busy_o && !done_o, "R8 reset state",
        {cs_n_o, tx_valid_o, busy_o, done_o}, 4'b1000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run(100, 264, 264, 9, 0, 0, 0, "R1 misaligned offset");
    run(264, 300, 264, 9, 0, 0, 0, "R1 misaligned length");
    run(0, 256, 0, 8, 0, 0, 0, "R1 zero page size");
    run(528, 0, 264, 9, 0, 0, 0, "R2 zero length");
    run(3 * 264, 264, 264, 9, 1, 0, 0, "R4 single page");
    run(16 * 264, 12 * 264, 264, 9, 2, 0, 0, "R3 block then pages");
    run(0, 8 * 256, 256, 8, 0, 0, 0, "R3 one block");
    run(0, 7 * 256, 256, 8, 1, 0, 0, "R3 short tail pages");
    run(3 * 512, 22 * 512, 512, 9, 0, 0, 0, "R6 unaligned start block");
    run(4000 * 1056, 2 * 1056, 1056, 11, 0, 0, 0, "R4 high address");
    run(8 * 528, 9 * 528, 528, 10, 1, 0, 1, "R10 R11 config change ignored");
    run(5 * 264, 3 * 264, 264, 9, 100000, 1, 0, "R7 poll timeout");
    run(264, 264, 264, 9, 3, 0, 0, "R7 recovery after timeout");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule